// File: doc/BRIEF.md
# General-Purpose Register File with Write-Through Read Ports

This block is the integer register file for a five-stage load-store pipeline. The decode stage uses two independent read ports, and each of them returns data combinationally. The write-back stage updates the file through a single port on the clock edge. Register zero is wired to a constant zero, so writes aimed at it are dropped.

The decode and write-back stages share the file, and a write and a read of the same register often fall in the same cycle. To cover this case, each read port compares its own address with the write address. When write enable is high and the addresses match, the port returns the incoming write data in place of the stored word. The effect is the same as writing in the first half of the cycle and reading in the second. Both the register width and the register count are parameters, with defaults of 64 bits and 32 registers. An active-low synchronous reset clears every register.

Top module: `gpr_file`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising clock edge), every register reads as zero on both ports until it is written.
- R2: A read of address 0 on either port returns zero in every cycle, including after write attempts to address 0.
- R3: When wr_en is high and wr_addr is not zero, the register wr_addr takes wr_data at the rising clock edge, and both ports return that value from the next cycle onward.
- R4: When wr_en is low, no register changes, whatever values wr_addr and wr_data carry.
- R5: When wr_en is high, wr_addr is not zero and rd_a_addr equals wr_addr, rd_a_data returns wr_data in that same cycle.
- R6: The same-cycle forwarding of R5 applies to port B on its own, based only on rd_b_addr, so port A can read a different register in that cycle.
- R7: A write to address 0 is never forwarded and never stored, so a read of address 0 during that write returns zero.
- R8: The two ports read different registers at the same time without interfering with each other.
- R9: A reset applied in the middle of operation clears registers that were written earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all registers |
| rd_a_addr | input | 5 | Register index for read port A |
| rd_a_data | output | 64 | Data from read port A, combinational |
| rd_b_addr | input | 5 | Register index for read port B |
| rd_b_data | output | 64 | Data from read port B, combinational |
| wr_en | input | 1 | Write enable from the write-back stage |
| wr_addr | input | 5 | Register index to write |
| wr_data | input | 64 | Data to write |

## Verification
The main stimulus is a long run of random writes and dual reads, with the addresses biased toward a small set of registers. This makes the reads hit fresh data, stale data and same-cycle collisions. A shadow array separates three cases: a correct forward, a read of the stored word one cycle too late, and a write that reached the wrong register. Directed cycles cover cases that random stimulus rarely produces. One writes address 0 while both ports read it, which separates a zero register that is truly hardwired from one that is merely masked on the port. One drives data with write enable low. One forwards on port B only while port A reads elsewhere. One resets in the middle of a run.

// File: rtl/gpr_file_pkg.sv
// Package: default geometry of the register file and a shared forwarding test.
// Assumes index 0 is the hardwired zero register.
package gpr_file_pkg;

    localparam int DEF_DATA_W   = 64;
    localparam int DEF_NUM_REGS = 32;

    // Forward condition: write active, same index, and the index is not zero.
    function automatic logic fwd_hit(input logic we, input logic [31:0] waddr,
                                     input logic [31:0] raddr);
        return we && (waddr == raddr) && (waddr != 32'd0);
    endfunction

endpackage

// File: rtl/gpr_store.sv
// Module: gpr_store
// Storage array holding one flop row per register. Row 0 is a constant zero.
// Assumes an active-low synchronous reset and a single write port.
module gpr_store #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);

    // Row 0 has no storage; it is tied to zero.
    assign regs[0] = '0;

    genvar gi;
    generate
        for (gi = 1; gi < NUM_REGS; gi++) begin : g_row
            logic row_we;
            logic [DATA_W-1:0] row_q;

            // Decode: this row is selected for write.
            assign row_we = wr_en && (wr_addr == ADDR_W'(gi));

            // Row update: cleared on reset, loaded on a selected write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    row_q <= '0;
                else if (row_we)
                    row_q <= wr_data;
            end

            assign regs[gi] = row_q;
        end
    endgenerate

endmodule

// File: rtl/gpr_read_port.sv
// Module: gpr_read_port
// One combinational read port. It returns the stored row, or the in-flight
// write data when the write targets the same nonzero index in this cycle.
// Assumes regs[0] is already zero.
module gpr_read_port #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [DATA_W-1:0]                rd_data
);
    import gpr_file_pkg::*;

    logic hit;

    // Forward detection for this port only.
    assign hit = fwd_hit(wr_en, 32'(wr_addr), 32'(rd_addr));

    // Output select: forwarded data, zero for index 0, else the stored row.
    always_comb begin
        if (rd_addr == '0)
            rd_data = '0;
        else if (hit)
            rd_data = wr_data;
        else
            rd_data = regs[rd_addr];
    end

endmodule

// File: rtl/gpr_file.sv
// Module: gpr_file (top)
// Register file with two forwarding read ports and one synchronous write port.
// The two read ports come from one generate loop and are then mapped onto
// named pins. Assumes NUM_REGS is a power of two.
module gpr_file #(
    parameter int DATA_W   = gpr_file_pkg::DEF_DATA_W,
    parameter int NUM_REGS = gpr_file_pkg::DEF_NUM_REGS,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int NUM_RD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_v;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_v;

    // Gather read addresses and scatter read data to the named pins.
    assign rd_addr_v[0] = rd_a_addr;
    assign rd_addr_v[1] = rd_b_addr;
    assign rd_a_data    = rd_data_v[0];
    assign rd_b_data    = rd_data_v[1];

    gpr_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    genvar pi;
    generate
        for (pi = 0; pi < NUM_RD; pi++) begin : g_rd
            gpr_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) port_i (
                .regs    (regs),
                .rd_addr (rd_addr_v[pi]),
                .wr_en   (wr_en),
                .wr_addr (wr_addr),
                .wr_data (wr_data),
                .rd_data (rd_data_v[pi])
            );
        end
    endgenerate

endmodule

// File: rtl/gpr_file_chk.sv
// Module: gpr_file_chk
// Port-level assertion checker bound to gpr_file. It holds no model of the
// array and only relates pins across cycles.
module gpr_file_chk #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);

    logic seen_rst;   // a reset edge has occurred
    logic rst_prev;   // rst_n sampled at the previous edge

    // Track reset history so that no check relies on pre-reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
        else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
        rst_prev <= rst_n;
    end

    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0));                                 // R2
    AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr == '0) |-> (rd_b_data == '0));                                 // R2
    AST_ZERO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && rd_a_addr == '0) |-> (rd_a_data == '0));       // R7
    AST_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_a_addr == wr_addr) |-> (rd_a_data == wr_data)); // R5
    AST_FWD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_b_addr == wr_addr) |-> (rd_b_data == wr_data)); // R6
    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst === 1'b1 && rst_prev && $past(wr_en) && $past(wr_addr) != '0
         && rd_a_addr == $past(wr_addr)
         && !(wr_en && wr_addr == rd_a_addr)) |-> (rd_a_data == $past(wr_data))); // R3
    AST_RESET_CLEARS: assert property (@(posedge clk)
        (seen_rst === 1'b1 && rst_n && rst_prev === 1'b0
         && !(wr_en && wr_addr == rd_a_addr)) |-> (rd_a_data == '0));              // R1

endmodule

bind gpr_file gpr_file_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_addr (rd_b_addr),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/gpr_file_tb_top.sv
// Bench: random and directed traffic, checked against a shadow array.
module gpr_file_tb_top;

    localparam int DW = 64;
    localparam int NR = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] rd_a_addr, rd_b_addr, wr_addr;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
    logic          wr_en;

    logic [DW-1:0] shadow [NR];
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 0;

    always #5 clk = ~clk;   // 100 MHz

    gpr_file dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Expected read value from the requirements: zero, forwarded, or shadow.
    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] ra);
        if (ra == '0) return '0;
        if (wr_en && wr_addr == ra) return wr_data;
        return shadow[ra];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (t=%0t)", req, got, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, check before the rising edge, then
    // update the shadow to reflect the edge.
    task automatic cyc(input logic rst, input logic we, input logic [AW-1:0] wa,
                       input logic [DW-1:0] wd, input logic [AW-1:0] ra,
                       input logic [AW-1:0] rb, input string tag_a, input string tag_b);
        @(negedge clk);
        rst_n = rst; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb;
        #2;
        if (rst) begin
            check(tag_a, rd_a_data, exp_rd(ra));
            check(tag_b, rd_b_data, exp_rd(rb));
        end
        @(posedge clk);
        if (!rst) begin
            for (int i = 0; i < NR; i++) shadow[i] = '0;
        end else if (we && wa != '0) begin
            shadow[wa] = wd;
        end
    endtask

    function automatic string tag_of(input logic [AW-1:0] ra, input string fwd);
        if (ra == '0) return "R2";
        if (wr_en && wr_addr == ra) return fwd;
        return "R3";
    endfunction

    task automatic rnd_cyc();
        logic [AW-1:0] wa, ra, rb;
        logic          we;
        wa = AW'($urandom_range(0, 7));
        ra = ($urandom_range(0, 3) == 0) ? wa : AW'($urandom_range(0, 7));
        rb = ($urandom_range(0, 3) == 0) ? wa : AW'($urandom_range(0, 31));
        we = ($urandom_range(0, 3) != 0);
        @(negedge clk);
        rst_n = 1'b1; wr_en = we; wr_addr = wa;
        wr_data = {$urandom(), $urandom()};
        rd_a_addr = ra; rd_b_addr = rb;
        #2;
        check(tag_of(ra, "R5"), rd_a_data, exp_rd(ra));
        check(ra != rb ? "R8" : tag_of(rb, "R6"), rd_b_data, exp_rd(rb));
        @(posedge clk);
        if (we && wa != '0) shadow[wa] = wr_data;
    endtask

    initial begin
        void'($urandom(32'h5EED_0449));
        for (int i = 0; i < NR; i++) shadow[i] = '0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_a_addr = '0; rd_b_addr = '0;
        cyc(1'b0, 1'b0, '0, '0, '0, '0, "R1", "R1");
        cyc(1'b0, 1'b0, '0, '0, '0, '0, "R1", "R1");
        // R1: every register reads zero after reset
        for (int i = 0; i < NR; i += 2)
            cyc(1'b1, 1'b0, '0, '0, AW'(i), AW'(i + 1), "R1", "R1");
        // R3: write then read back on both ports next cycle
        cyc(1'b1, 1'b1, 5'd9, 64'hDEAD_BEEF_0123_4567, 5'd1, 5'd2, "R3", "R3");
        cyc(1'b1, 1'b0, '0, '0, 5'd9, 5'd9, "R3", "R3");
        // R7: write to zero while both ports read zero
        cyc(1'b1, 1'b1, 5'd0, {DW{1'b1}}, 5'd0, 5'd0, "R7", "R7");
        cyc(1'b1, 1'b0, '0, '0, 5'd0, 5'd0, "R2", "R2");
        // R4: disabled write to register 9 leaves it unchanged
        cyc(1'b1, 1'b0, 5'd9, 64'h1111_2222_3333_4444, 5'd10, 5'd9, "R4", "R4");
        cyc(1'b1, 1'b0, '0, '0, 5'd9, 5'd9, "R4", "R4");
        // R6: forward on port B only, port A reads register 9
        cyc(1'b1, 1'b1, 5'd20, 64'hA5A5_5A5A_F0F0_0F0F, 5'd9, 5'd20, "R8", "R6");
        // R5: forward on port A, port B reads register 20
        cyc(1'b1, 1'b1, 5'd31, 64'h0BAD_CAFE_1234_5678, 5'd31, 5'd20, "R5", "R8");
        // Random traffic
        for (int k = 0; k < 3000; k++) rnd_cyc();
        // R9: reset in the middle of a run clears the written registers
        cyc(1'b0, 1'b0, '0, '0, '0, '0, "R9", "R9");
        for (int i = 0; i < NR; i += 2)
            cyc(1'b1, 1'b0, '0, '0, AW'(i), AW'(i + 1), "R9", "R9");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule